// File: doc/BRIEF.md
# Asymmetric Dual-Port Memory with Side-Band Bits

This block is a synchronous memory with two independent ports. Each port has its own clock, enable, write enable, synchronous output set/reset, address, data and side-band bit buses. Both ports look into a single shared array of 16384 data bits and 2048 side-band bits. Each port picks its own total word width by parameter. A narrow port therefore sees one wide word as several consecutive small locations. The side-band bits are called parity bits, but the block never computes or checks them. It stores and returns them like any other bit.

Each port registers its output. A port can also load a fixed pattern into its output register instead of reading the array. Every control input (clock, enable, write enable, set/reset) can be given inverted polarity by parameter. An inverted clock makes the port work on falling edges. The block is used as a width-converting buffer between two clock domains, or as plain local storage where extra tag bits travel with the data.

Top module: `dpram_asym`

## Requirements
- R1: A port of total width w (1, 2, 4, 9, 18 or 36) has p parity bits (0, 0, 0, 1, 2 or 4 respectively) and w−p data bits. Its address bus has 14−log2(w−p) bits. Its input and output buses of each kind have the same width, so a 36-bit port has 32+4 bits and 9 address bits, and a 9-bit port has 8+1 bits and 11 address bits.
- R2: On the active edge of a port's clock, when both its enable and its write enable are active, the data and parity inputs are stored at the addressed location.
- R3: During a write, the port's outputs show the value just written on the following sample (write-first).
- R4: While a port's enable is inactive, that port writes nothing and its outputs keep their previous value.
- R5: When enable and set/reset are both active on an edge, the output register loads the port's set/reset pattern. The low w−p bits go to the data output and the next p bits go to the parity output. Set/reset never alters the array, and a write in the same cycle is still stored.
- R6: The array is 512 rows of 32 data bits and 4 parity bits. A port with d data bits uses address bits above log2(32/d) as the row and the low bits as the slice index s. It reaches data bits [s·d +: d] and parity bits [s·p +: p], so slice 0 is the least significant.
- R7: Parity bits have no generation or checking. Any value written is read back unchanged, on either port.
- R8: A write by either port is seen by reads on either port on a later edge. For each bit, the most recent write wins. Both ports writing the same bit on the same edge leaves that bit undefined.
- R9: Each of the four controls of each port has a polarity parameter. When it is set, the pin is active low, or falling-edge for the clock.
- R10: A synchronous active-low reset per port, sampled on that port's active edge, loads the set/reset pattern into that port's output registers and leaves the array untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A output set/reset |
| addr_a | input | 14−log2(dA) | Port A address |
| din_a | input | dA | Port A write data |
| dinp_a | input | max(pA,1) | Port A write parity (ignored when pA is 0) |
| dout_a | output | dA | Port A read data |
| doutp_a | output | max(pA,1) | Port A read parity (0 when pA is 0) |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B output set/reset |
| addr_b | input | 14−log2(dB) | Port B address |
| din_b | input | dB | Port B write data |
| dinp_b | input | max(pB,1) | Port B write parity (ignored when pB is 0) |
| dout_b | output | dB | Port B read data |
| doutp_b | output | max(pB,1) | Port B read parity (0 when pB is 0) |

## Verification
A wrong slice decode or write mask shows up at the ports as a neighbouring byte that changes or does not change. This appears on the first read of that row from the other port, one edge after the write. A bad last-writer flag makes a row read back data that one port has already overwritten. The checks therefore interleave narrow and wide writes to the same rows and read every slice from both sides. A wrong set/reset or enable path corrupts the output register on the very next edge, so those are checked immediately and followed by a read-back that proves the array was not touched.

// File: rtl/dpram_pkg.sv
// Shared geometry of the asymmetric dual-port memory: fixed row shape and
// width-dependent helper functions. Assumes widths from {1,2,4,9,18,36}.
package dpram_pkg;
    localparam int ROWS    = 512;
    localparam int ROW_AW  = 9;
    localparam int ROW_DW  = 32;
    localparam int ROW_PW  = 4;
    localparam int ROW_W   = ROW_DW + ROW_PW;
    localparam int TOTAL_W = 36;

    // Number of side-band bits carried by a port of total width w.
    function automatic int par_bits(input int w);
        case (w)
            9:       return 1;
            18:      return 2;
            36:      return 4;
            default: return 0;
        endcase
    endfunction

    // Data bits of a port of total width w.
    function automatic int data_bits(input int w);
        return w - par_bits(w);
    endfunction

    // Port-side width of the parity bus (never zero).
    function automatic int par_port_bits(input int w);
        return (par_bits(w) == 0) ? 1 : par_bits(w);
    endfunction

    // Address bits of a port of total width w.
    function automatic int addr_bits(input int w);
        return ROW_AW + $clog2(ROW_DW / data_bits(w));
    endfunction
endpackage

// File: rtl/dpram_bank.sv
// One writer's copy of the array plus a per-bit last-writer flag.
// The two banks are merged by the top: a bit belongs to writer 0 when
// both flags agree, else to writer 1. Assumes mask bits are set only
// for bits this writer owns in the current cycle.
module dpram_bank
    import dpram_pkg::*;
#(
    parameter bit WRITER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  wmask,
    input  logic [ROW_AW-1:0] wrow,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [ROW_W-1:0]  peer_flag,
    input  logic [ROW_AW-1:0] rrow0,
    input  logic [ROW_AW-1:0] rrow1,
    output logic [ROW_W-1:0]  rdata0,
    output logic [ROW_W-1:0]  rflag0,
    output logic [ROW_W-1:0]  rdata1,
    output logic [ROW_W-1:0]  rflag1
);
    logic [ROW_W-1:0] mem [ROWS];
    logic [ROW_W-1:0] flg [ROWS];
    logic [ROW_W-1:0] new_flag;

    // Flag value that marks this writer as the latest owner of a bit.
    always_comb new_flag = WRITER ? ~peer_flag : peer_flag;

    // Masked write of data and ownership flags for the addressed row.
    always_ff @(posedge clk) begin
        if (|wmask) begin
            mem[wrow] <= (mem[wrow] & ~wmask) | (wdata & wmask);
            flg[wrow] <= (flg[wrow] & ~wmask) | (new_flag & wmask);
        end
    end

    // Asynchronous read taps for both ports' rows.
    assign rdata0 = mem[rrow0];
    assign rflag0 = flg[rrow0];
    assign rdata1 = mem[rrow1];
    assign rflag1 = flg[rrow1];

    // Masked bits of the written row hold the written value afterwards.
    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|wmask) |=> ((mem[$past(wrow)] & $past(wmask)) == ($past(wdata) & $past(wmask))));
endmodule

// File: rtl/dpram_port.sv
// One access port: control polarity, address split into row and slice,
// write mask generation, and the registered output with set/reset.
// Assumes W is a legal width; rword_i is the merged row at row_o.
module dpram_port
    import dpram_pkg::*;
#(
    parameter int                 W       = 36,
    parameter bit                 INV_CLK = 1'b0,
    parameter bit                 INV_EN  = 1'b0,
    parameter bit                 INV_WE  = 1'b0,
    parameter bit                 INV_SSR = 1'b0,
    parameter logic [TOTAL_W-1:0] SRVAL   = '0,
    localparam int                P       = par_bits(W),
    localparam int                DW      = W - P,
    localparam int                PPW     = (P == 0) ? 1 : P,
    localparam int                S       = ROW_DW / DW,
    localparam int                SB      = $clog2(S),
    localparam int                AW      = ROW_AW + SB
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic              ssr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     di_i,
    input  logic [PPW-1:0]    dip_i,
    input  logic [ROW_W-1:0]  rword_i,
    output logic [DW-1:0]     do_o,
    output logic [PPW-1:0]    dop_o,
    output logic              clk_o,
    output logic [ROW_AW-1:0] row_o,
    output logic [ROW_W-1:0]  wmask_o,
    output logic [ROW_W-1:0]  wdata_o
);
    logic              clk_eff;
    logic              en, we, ssr, wr;
    int                slice;
    logic [ROW_DW-1:0] dmask, dwdata;
    logic [ROW_PW-1:0] pmask, pwdata;
    logic [DW-1:0]     rd_data;
    logic [PPW-1:0]    rd_par, par_in, par_sr;
    logic [DW-1:0]     do_q;
    logic [PPW-1:0]    dop_q;

    // Apply the configured polarity to every control input.
    assign clk_eff = clk_i ^ INV_CLK;
    assign en      = en_i ^ INV_EN;
    assign we      = we_i ^ INV_WE;
    assign ssr     = ssr_i ^ INV_SSR;
    assign wr      = en & we;
    assign clk_o   = clk_eff;

    // Split the port address into row and slice index.
    always_comb begin
        row_o = ROW_AW'(addr_i >> SB);
        slice = int'(addr_i) & (S - 1);
    end

    // Data-lane mask and aligned write data for the addressed slice.
    always_comb begin
        dmask  = '0;
        dwdata = '0;
        if (wr) begin
            dmask[slice*DW +: DW]  = '1;
            dwdata[slice*DW +: DW] = di_i;
        end
    end

    // Data-lane slice of the merged row.
    assign rd_data = rword_i[slice*DW +: DW];

    generate
        if (P > 0) begin : g_par
            // Parity-lane mask, write data and read slice.
            always_comb begin
                pmask  = '0;
                pwdata = '0;
                if (wr) begin
                    pmask[slice*P +: P]  = '1;
                    pwdata[slice*P +: P] = dip_i;
                end
            end
            assign rd_par = rword_i[ROW_DW + slice*P +: P];
            assign par_in = dip_i;
            assign par_sr = SRVAL[DW +: P];
        end else begin : g_nopar
            assign pmask  = '0;
            assign pwdata = '0;
            assign rd_par = '0;
            assign par_in = '0;
            assign par_sr = '0;
        end
    endgenerate

    assign wmask_o = {pmask, dmask};
    assign wdata_o = {pwdata, dwdata};

    // Output register: reset, set/reset, write-first, read or hold.
    always_ff @(posedge clk_eff) begin
        if (!rst_n) begin
            do_q  <= SRVAL[DW-1:0];
            dop_q <= par_sr;
        end else if (en) begin
            if (ssr) begin
                do_q  <= SRVAL[DW-1:0];
                dop_q <= par_sr;
            end else if (we) begin
                do_q  <= di_i;
                dop_q <= par_in;
            end else begin
                do_q  <= rd_data;
                dop_q <= rd_par;
            end
        end
    end

    assign do_o  = do_q;
    assign dop_o = dop_q;

    assert_write_first_R3: assert property (@(posedge clk_eff) disable iff (!rst_n)
        (en && we && !ssr) |=> (do_o == $past(di_i)));
    assert_idle_hold_R4: assert property (@(posedge clk_eff) disable iff (!rst_n)
        (!en) |=> ($stable(do_o) && $stable(dop_o)));
    assert_srval_load_R5: assert property (@(posedge clk_eff) disable iff (!rst_n)
        (en && ssr) |=> ((do_o == SRVAL[DW-1:0]) && (dop_o == par_sr)));
    assert_reset_value_R10: assert property (@(posedge clk_eff) disable iff (!rst_n)
        $rose(rst_n) |-> ((do_o == SRVAL[DW-1:0]) && (dop_o == par_sr)));
endmodule

// File: rtl/dpram_asym.sv
// Top of the asymmetric true dual-port memory. Two ports, each with its
// own width and control polarity, share one 512 x 36 array held as two
// writer banks merged bit by bit through last-writer flags.
// Assumes the ports never write the same bit on the same edge.
module dpram_asym
    import dpram_pkg::*;
#(
    parameter int                 WIDTH_A   = 36,
    parameter int                 WIDTH_B   = 9,
    parameter bit                 INV_CLK_A = 1'b0,
    parameter bit                 INV_EN_A  = 1'b0,
    parameter bit                 INV_WE_A  = 1'b0,
    parameter bit                 INV_SSR_A = 1'b0,
    parameter bit                 INV_CLK_B = 1'b0,
    parameter bit                 INV_EN_B  = 1'b0,
    parameter bit                 INV_WE_B  = 1'b0,
    parameter bit                 INV_SSR_B = 1'b0,
    parameter logic [TOTAL_W-1:0] SRVAL_A   = '0,
    parameter logic [TOTAL_W-1:0] SRVAL_B   = '0
) (
    input  logic                                clk_a,
    input  logic                                rst_a_n,
    input  logic                                en_a,
    input  logic                                we_a,
    input  logic                                ssr_a,
    input  logic [addr_bits(WIDTH_A)-1:0]       addr_a,
    input  logic [data_bits(WIDTH_A)-1:0]       din_a,
    input  logic [par_port_bits(WIDTH_A)-1:0]   dinp_a,
    output logic [data_bits(WIDTH_A)-1:0]       dout_a,
    output logic [par_port_bits(WIDTH_A)-1:0]   doutp_a,
    input  logic                                clk_b,
    input  logic                                rst_b_n,
    input  logic                                en_b,
    input  logic                                we_b,
    input  logic                                ssr_b,
    input  logic [addr_bits(WIDTH_B)-1:0]       addr_b,
    input  logic [data_bits(WIDTH_B)-1:0]       din_b,
    input  logic [par_port_bits(WIDTH_B)-1:0]   dinp_b,
    output logic [data_bits(WIDTH_B)-1:0]       dout_b,
    output logic [par_port_bits(WIDTH_B)-1:0]   doutp_b
);
    logic              bk_clk   [2];
    logic              bk_rstn  [2];
    logic [ROW_W-1:0]  bk_mask  [2];
    logic [ROW_W-1:0]  bk_wdata [2];
    logic [ROW_AW-1:0] bk_row   [2];
    logic [ROW_W-1:0]  bk_peer  [2];
    logic [ROW_W-1:0]  rd0      [2];
    logic [ROW_W-1:0]  fl0      [2];
    logic [ROW_W-1:0]  rd1      [2];
    logic [ROW_W-1:0]  fl1      [2];
    logic [ROW_W-1:0]  word_a, word_b, own_a, own_b;

    dpram_port #(
        .W(WIDTH_A), .INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
        .INV_WE(INV_WE_A), .INV_SSR(INV_SSR_A), .SRVAL(SRVAL_A)
    ) u_port_a (
        .clk_i(clk_a), .rst_n(rst_a_n), .en_i(en_a), .we_i(we_a),
        .ssr_i(ssr_a), .addr_i(addr_a), .di_i(din_a), .dip_i(dinp_a),
        .rword_i(word_a), .do_o(dout_a), .dop_o(doutp_a),
        .clk_o(bk_clk[0]), .row_o(bk_row[0]), .wmask_o(bk_mask[0]),
        .wdata_o(bk_wdata[0])
    );

    dpram_port #(
        .W(WIDTH_B), .INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
        .INV_WE(INV_WE_B), .INV_SSR(INV_SSR_B), .SRVAL(SRVAL_B)
    ) u_port_b (
        .clk_i(clk_b), .rst_n(rst_b_n), .en_i(en_b), .we_i(we_b),
        .ssr_i(ssr_b), .addr_i(addr_b), .di_i(din_b), .dip_i(dinp_b),
        .rword_i(word_b), .do_o(dout_b), .dop_o(doutp_b),
        .clk_o(bk_clk[1]), .row_o(bk_row[1]), .wmask_o(bk_mask[1]),
        .wdata_o(bk_wdata[1])
    );

    assign bk_rstn[0] = rst_a_n;
    assign bk_rstn[1] = rst_b_n;

    // Each writer compares against the other's flag at its own write row.
    assign bk_peer[0] = fl0[1];
    assign bk_peer[1] = fl1[0];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_bank
            dpram_bank #(.WRITER(g[0])) u_bank (
                .clk(bk_clk[g]), .rst_n(bk_rstn[g]), .wmask(bk_mask[g]),
                .wrow(bk_row[g]), .wdata(bk_wdata[g]), .peer_flag(bk_peer[g]),
                .rrow0(bk_row[0]), .rrow1(bk_row[1]),
                .rdata0(rd0[g]), .rflag0(fl0[g]),
                .rdata1(rd1[g]), .rflag1(fl1[g])
            );
        end
    endgenerate

    // Merge the two banks bit by bit: equal flags select writer A.
    always_comb begin
        own_a  = fl0[0] ^ fl0[1];
        own_b  = fl1[0] ^ fl1[1];
        word_a = (rd0[0] & ~own_a) | (rd0[1] & own_a);
        word_b = (rd1[0] & ~own_b) | (rd1[1] & own_b);
    end
endmodule

// File: tb/dpram_asym_tb.sv
// Bench: port A 36 bits wide, port B 9 bits wide with an active-low enable.
module dpram_asym_tb;
    typedef struct packed {
        logic        port;   // 0 = A, 1 = B
        logic        en;     // logical enable (bench maps to pin)
        logic        we;
        logic        ssr;
        logic [13:0] addr;
        logic [31:0] di;
        logic [3:0]  dip;
        logic [31:0] exp_do;
        logic [3:0]  exp_dop;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,1'b0, 14'd3,    32'h11223344, 4'h5, 32'h11223344, 4'h5, 4'd3}, // R3 R2
        '{1'b1,1'b1,1'b0,1'b0, 14'd12,   32'h0,        4'h0, 32'h44,       4'h1, 4'd6}, // R6
        '{1'b1,1'b1,1'b0,1'b0, 14'd13,   32'h0,        4'h0, 32'h33,       4'h0, 4'd6}, // R6
        '{1'b1,1'b1,1'b0,1'b0, 14'd15,   32'h0,        4'h0, 32'h11,       4'h0, 4'd6}, // R6
        '{1'b1,1'b1,1'b0,1'b0, 14'd14,   32'h0,        4'h0, 32'h22,       4'h1, 4'd7}, // R7
        '{1'b1,1'b1,1'b1,1'b0, 14'd14,   32'hAB,       4'h0, 32'hAB,       4'h0, 4'd3}, // R3
        '{1'b0,1'b1,1'b0,1'b0, 14'd3,    32'h0,        4'h0, 32'h11AB3344, 4'h1, 4'd8}, // R8
        '{1'b0,1'b0,1'b1,1'b0, 14'd3,    32'hFFFFFFFF, 4'hF, 32'h11AB3344, 4'h1, 4'd4}, // R4
        '{1'b0,1'b1,1'b0,1'b0, 14'd3,    32'h0,        4'h0, 32'h11AB3344, 4'h1, 4'd4}, // R4
        '{1'b0,1'b1,1'b0,1'b1, 14'd3,    32'h0,        4'h0, 32'h12345678, 4'hA, 4'd5}, // R5
        '{1'b0,1'b1,1'b0,1'b0, 14'd3,    32'h0,        4'h0, 32'h11AB3344, 4'h1, 4'd5}, // R5
        '{1'b1,1'b1,1'b0,1'b1, 14'd0,    32'h0,        4'h0, 32'hC3,       4'h1, 4'd5}, // R5
        '{1'b1,1'b1,1'b1,1'b0, 14'd0,    32'h5A,       4'h1, 32'h5A,       4'h1, 4'd2}, // R2
        '{1'b0,1'b1,1'b1,1'b0, 14'd1,    32'hDEADBEEF, 4'hC, 32'hDEADBEEF, 4'hC, 4'd2}, // R2
        '{1'b1,1'b1,1'b0,1'b0, 14'd4,    32'h0,        4'h0, 32'hEF,       4'h0, 4'd8}, // R8
        '{1'b1,1'b1,1'b0,1'b0, 14'd7,    32'h0,        4'h0, 32'hDE,       4'h1, 4'd7}, // R7
        '{1'b1,1'b1,1'b0,1'b0, 14'd0,    32'h0,        4'h0, 32'h5A,       4'h1, 4'd6}, // R6
        '{1'b0,1'b1,1'b1,1'b0, 14'd511,  32'hCAFEF00D, 4'h3, 32'hCAFEF00D, 4'h3, 4'd1}, // R1
        '{1'b1,1'b1,1'b0,1'b0, 14'd2047, 32'h0,        4'h0, 32'hCA,       4'h0, 4'd1}, // R1
        '{1'b1,1'b1,1'b0,1'b0, 14'd2044, 32'h0,        4'h0, 32'h0D,       4'h1, 4'd1}, // R1
        '{1'b1,1'b1,1'b1,1'b1, 14'd2045, 32'h77,       4'h0, 32'hC3,       4'h1, 4'd5}, // R5
        '{1'b0,1'b1,1'b0,1'b0, 14'd511,  32'h0,        4'h0, 32'hCAFE770D, 4'h1, 4'd5}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_a, we_a, ssr_a, en_b, we_b, ssr_b;
    logic [8:0]  addr_a;
    logic [10:0] addr_b;
    logic [31:0] din_a, dout_a;
    logic [3:0]  dinp_a, doutp_a;
    logic [7:0]  din_b, dout_b;
    logic [0:0]  dinp_b, doutp_b;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    dpram_asym #(
        .WIDTH_A(36), .WIDTH_B(9), .INV_EN_B(1'b1),
        .SRVAL_A(36'hA_1234_5678), .SRVAL_B(36'h1C3)
    ) u_dut (
        .clk_a(clk), .rst_a_n(rst_n), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a),
        .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a),
        .dout_a(dout_a), .doutp_a(doutp_a),
        .clk_b(clk), .rst_b_n(rst_n), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b),
        .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b),
        .dout_b(dout_b), .doutp_b(doutp_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Both ports idle; port B enable pin is active low (R9).
    task automatic idle();
        en_a = 1'b0; we_a = 1'b0; ssr_a = 1'b0;
        en_b = 1'b1; we_b = 1'b0; ssr_b = 1'b0;
        addr_a = '0; din_a = '0; dinp_a = '0;
        addr_b = '0; din_b = '0; dinp_b = '0;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R10: reset loads the set/reset patterns
        check("R10 reset dout_a", dout_a, 32'h12345678);
        check("R10 reset doutp_a", 32'(doutp_a), 32'hA);
        check("R10 reset dout_b", 32'(dout_b), 32'hC3);
        check("R10 reset doutp_b", 32'(doutp_b), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            if (!VEC[i].port) begin
                en_a = VEC[i].en; we_a = VEC[i].we; ssr_a = VEC[i].ssr;
                addr_a = VEC[i].addr[8:0]; din_a = VEC[i].di; dinp_a = VEC[i].dip;
            end else begin
                en_b = ~VEC[i].en; we_b = VEC[i].we; ssr_b = VEC[i].ssr;
                addr_b = VEC[i].addr[10:0]; din_b = VEC[i].di[7:0]; dinp_b = VEC[i].dip[0:0];
            end
            @(posedge clk);
            #1;
            if (!VEC[i].port) begin
                check($sformatf("R%0d vec %0d dout_a", VEC[i].req, i), dout_a, VEC[i].exp_do);
                check($sformatf("R%0d vec %0d doutp_a", VEC[i].req, i), 32'(doutp_a), 32'(VEC[i].exp_dop));
            end else begin
                check($sformatf("R%0d vec %0d dout_b", VEC[i].req, i), 32'(dout_b), VEC[i].exp_do);
                check($sformatf("R%0d vec %0d doutp_b", VEC[i].req, i), 32'(doutp_b), 32'(VEC[i].exp_dop[0]));
            end
        end

        // R9: enable pin high is inactive on port B, so no write and hold
        @(negedge clk);
        idle();
        en_b = 1'b1; we_b = 1'b1; addr_b = 11'd14; din_b = 8'h77; dinp_b = 1'b1;
        @(posedge clk);
        #1;
        check("R9 inactive pin hold dout_b", 32'(dout_b), 32'hC3);
        @(negedge clk);
        idle();
        en_b = 1'b0; addr_b = 11'd14;
        @(posedge clk);
        #1;
        check("R9 no write through high pin", 32'(dout_b), 32'hAB);
        check("R9 parity untouched", 32'(doutp_b), 32'h0);

        // R10: mid-run reset restores patterns, array keeps contents
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 mid reset dout_a", dout_a, 32'h12345678);
        check("R10 mid reset dout_b", 32'(dout_b), 32'hC3);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        en_a = 1'b1; addr_a = 9'd3;
        @(posedge clk);
        #1;
        check("R10 array kept dout_a", dout_a, 32'h11AB3344);
        check("R10 array kept doutp_a", 32'(doutp_a), 32'h1);

        summary();
    end
endmodule